// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Selectable Parity and Multi-Drop Addressing

This block is a full-duplex asynchronous serial port. It holds a transmitter and a receiver that share one baud tick generator. A 3-bit mode input sets what goes in the slot after the eight data bits. The slot can carry even or odd parity, a constant 0, or a constant 1. It can also be left out of the frame, or carry an address/data marker for multi-drop buses. The receiver checks the same slot against the rule that the mode selects. On a mismatch it raises a sticky error flag, and software clears that flag with a reset-status strobe.

In multi-drop mode a character sent after a send-address strobe goes out with the slot at 1. Any other character goes out with the slot at 0. On the receive side, any character whose slot is 1 sets the error flag. Software uses that flag to spot address characters among the data stream.

Top module: `uart_md`

## Requirements
- R1: The line idles at 1. A frame is a start bit at 0, then eight data bits LSB first, then the optional parity slot, then one stop bit at 1. Each bit lasts OVS ticks, and one tick occurs every `baud_div` clock cycles (0 or 1 gives a tick every cycle).
- R2: A character is accepted in a cycle where `tx_valid` and `tx_ready` are both 1. The start bit appears on `txd` the next cycle, and `tx_ready` stays 0 until the stop bit has been sent.
- R3: The mode codes select the slot content. Code 0 is even parity, where the data ones plus the slot add up to an even count. Code 1 is odd parity. Code 2 is space, a constant 0. Code 3 is mark, a constant 1. Codes 4 and 5 mean no parity. Codes 6 and 7 select multi-drop. Example: for data 0x41, even gives 0, odd gives 1, space gives 0 and mark gives 1.
- R4: With code 4 or 5 the frame has no parity slot. It is 10 bits long, and the receiver never reports a parity error.
- R5: In multi-drop mode a character carries slot 1 only if `send_addr` was pulsed since the previous accepted character, or in the same cycle as its acceptance. Otherwise it carries slot 0. Each accepted character consumes the pending request.
- R6: The receiver flags a parity error in these cases: an even or odd parity mismatch, a 1 under space, a 0 under mark, and a 1 under multi-drop.
- R7: The receiver starts a frame only after the line has been low for OVS/2 consecutive ticks. A shorter low pulse is ignored. Each later bit is sampled OVS ticks after the previous sample.
- R8: At the stop-bit sample, `rx_valid` pulses for one cycle with the byte on `rx_data`. Any parity error becomes visible on `par_err` in that same cycle.
- R9: `par_err` is sticky and returns to 0 only through `rst_sta`.
- R10: When a new error and `rst_sta` occur in the same cycle, `par_err` is set.
- R11: After reset, `txd` is 1, `tx_ready` is 1, `rx_valid` is 0 and `par_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Parity/slot mode code |
| baud_div | input | DIV_W | Clock cycles per oversampling tick |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_ready | output | 1 | Transmitter idle, byte can be taken |
| send_addr | input | 1 | Mark the next sent character as an address |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe: received byte is on `rx_data` |
| par_err | output | 1 | Sticky parity/address flag |
| rst_sta | input | 1 | Clear `par_err` |

## Verification
The receiver latches the mode at start confirmation. If it latched the wrong code, the error would show on `par_err` at the stop-bit sample, about ten bit times later. A lost or stale send-address request shows on the very next frame's slot on `txd`. A transmitter that counts the frame length wrongly keeps `tx_ready` low past the tenth bit in no-parity mode. A faulty start-confirm counter either delivers a byte after a short glitch or moves every sample point off the bit centre, and the corrupted `rx_data` appears one frame later.

// File: rtl/uart_md_pkg.sv
// Package: shared slot-kind type and decode helpers for the serial port.
// Assumes eight-bit characters.
package uart_md_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PK_EVEN  = 3'd0,
        PK_ODD   = 3'd1,
        PK_SPACE = 3'd2,
        PK_MARK  = 3'd3,
        PK_NONE  = 3'd4,
        PK_MDROP = 3'd5
    } par_kind_e;

    // Map the external 3-bit mode code onto a slot kind.
    function automatic par_kind_e decode_mode(input logic [2:0] code);
        case (code)
            3'd0:         return PK_EVEN;
            3'd1:         return PK_ODD;
            3'd2:         return PK_SPACE;
            3'd3:         return PK_MARK;
            3'd6, 3'd7:   return PK_MDROP;
            default:      return PK_NONE;
        endcase
    endfunction

    // Value the slot must carry for a character of this kind.
    function automatic logic slot_value(input par_kind_e kind,
                                        input logic [BYTE_W-1:0] data,
                                        input logic addr);
        case (kind)
            PK_EVEN:  return ^data;
            PK_ODD:   return ~^data;
            PK_MARK:  return 1'b1;
            PK_MDROP: return addr;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_md_baud.sv
// Module: oversampling tick generator.
// Emits a one-cycle tick every div_i clocks; a divisor of 0 or 1 ticks every cycle.
module uart_md_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // Count clocks and pulse the tick on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q + 1'b1 >= div_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R1
    tick_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i > 1 && tick_o) |=> !tick_o);
endmodule

// File: rtl/uart_md_tx.sv
// Module: frame transmitter.
// Loads start, data, optional slot and stop into a shifter on acceptance and shifts
// one bit per OVS ticks. Mode is sampled at acceptance and assumed stable meanwhile.
module uart_md_tx
    import uart_md_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [2:0]        mode_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              valid_i,
    input  logic              send_addr_i,
    output logic              ready_o,
    output logic              txd_o
);
    localparam int CW = $clog2(OVS);
    localparam int FRAME_W = BYTE_W + 3;
    localparam logic [CW-1:0] LAST_TICK = CW'(OVS - 1);

    logic               busy_q;
    logic [CW-1:0]      sub_q;
    logic [3:0]         left_q;
    logic [FRAME_W-1:0] sh_q;
    logic               addr_pend_q;
    logic               load;
    logic               slot_bit;
    par_kind_e          kind;

    assign kind     = decode_mode(mode_i);
    assign load     = valid_i && !busy_q;
    assign slot_bit = (kind == PK_NONE) ? 1'b1
                                        : slot_value(kind, data_i, addr_pend_q | send_addr_i);
    assign ready_o  = !busy_q;
    assign txd_o    = busy_q ? sh_q[0] : 1'b1;

    // Hold an address request until the next accepted character consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_pend_q <= 1'b0;
        else        addr_pend_q <= (addr_pend_q && !load) || (send_addr_i && !load);
    end

    // Load a frame on acceptance, then shift one bit every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sub_q  <= '0;
            left_q <= '0;
            sh_q   <= '1;
        end else if (load) begin
            busy_q <= 1'b1;
            sub_q  <= '0;
            left_q <= (kind == PK_NONE) ? 4'(BYTE_W + 2) : 4'(BYTE_W + 3);
            sh_q   <= {1'b1, slot_bit, data_i, 1'b0};
        end else if (busy_q && tick_i) begin
            if (sub_q == LAST_TICK) begin
                sub_q  <= '0;
                sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                left_q <= left_q - 1'b1;
                if (left_q == 4'd1) busy_q <= 1'b0;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    // R11
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> txd_o);
    // R2
    accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && valid_i) |=> (!ready_o && !txd_o));
    // R2
    busy_only_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(valid_i));
endmodule

// File: rtl/uart_md_rx.sv
// Module: frame receiver with slot checker and sticky error flag.
// Synchronises rxd, confirms the start bit after OVS/2 low ticks, samples each bit centre
// and checks the slot against the mode latched at start confirmation.
module uart_md_rx
    import uart_md_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic [2:0]        mode_i,
    input  logic              rst_sta_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] HALF_TICK = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST_TICK = CW'(OVS - 1);

    logic [1:0]        sync_q;
    logic              rxs;
    logic              busy_q;
    logic [CW-1:0]     cnt_q;
    logic [3:0]        idx_q;
    logic [BYTE_W-1:0] data_q;
    logic              slot_q;
    par_kind_e         kind_q;
    logic              has_slot, sample_now, last_bit, bad_slot, err_set;

    assign rxs        = sync_q[1];
    assign has_slot   = (kind_q != PK_NONE);
    assign sample_now = busy_q && tick_i && (cnt_q == LAST_TICK);
    assign last_bit   = (idx_q == (has_slot ? 4'(BYTE_W + 1) : 4'(BYTE_W)));
    assign bad_slot   = has_slot && (slot_q != slot_value(kind_q, data_q, 1'b0));
    assign err_set    = sample_now && last_bit && bad_slot;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd_i};
    end

    // Start detection, bit-centre sampling and byte delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            slot_q  <= 1'b0;
            kind_q  <= PK_NONE;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (!busy_q) begin
                if (tick_i) begin
                    if (rxs) begin
                        cnt_q <= '0;
                    end else if (cnt_q == HALF_TICK) begin
                        busy_q <= 1'b1;
                        cnt_q  <= '0;
                        idx_q  <= '0;
                        kind_q <= decode_mode(mode_i);
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end else if (tick_i) begin
                if (cnt_q == LAST_TICK) begin
                    cnt_q <= '0;
                    if (idx_q < 4'(BYTE_W))       data_q[idx_q[2:0]] <= rxs;
                    else if (idx_q == 4'(BYTE_W)) slot_q <= rxs;
                    if (last_bit) begin
                        busy_q  <= 1'b0;
                        valid_o <= 1'b1;
                        data_o  <= data_q;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Sticky error: set wins over the reset-status strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= err_set || (err_o && !rst_sta_i);
    end

    // R8
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !rst_sta_i) |=> err_o);
    // R10
    err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set && rst_sta_i) |=> err_o);
    // R4
    none_never_errs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && kind_q == PK_NONE) |=> !$rose(err_o));
    // R8
    err_rises_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> valid_o);
endmodule

// File: rtl/uart_md.sv
// Module: top of the serial port; shares one tick generator between transmitter and receiver.
// Assumes mode and baud_div change only while both directions are idle.
module uart_md
    import uart_md_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              send_addr,
    output logic              txd,
    input  logic              rxd,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              par_err,
    input  logic              rst_sta
);
    logic tick;

    uart_md_baud #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .div_i(baud_div), .tick_o(tick)
    );

    uart_md_tx #(.OVS(OVS)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode),
        .data_i(tx_data), .valid_i(tx_valid), .send_addr_i(send_addr),
        .ready_o(tx_ready), .txd_o(txd)
    );

    uart_md_rx #(.OVS(OVS)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd), .mode_i(mode),
        .rst_sta_i(rst_sta), .data_o(rx_data), .valid_o(rx_valid), .err_o(par_err)
    );
endmodule

// File: tb/uart_md_tb.sv
module uart_md_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 2;
    localparam int BIT_CLKS = 16 * DIV;
    localparam int NVEC = 15;
    // fields: [15:13] mode, [12:5] data, [4] send_addr, [3] expected tx slot,
    //         [2] slot driven into rx, [1] expected error, [0] unused
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {3'd0, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd0, 8'h41, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd1, 8'h41, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd1, 8'h07, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd2, 8'h41, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd2, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd3, 8'h41, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'd3, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd4, 8'h41, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'd5, 8'h41, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'd6, 8'h55, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd6, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd7, 8'hA3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'd7, 8'hA3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [15:0] baud_div = 16'(DIV);
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       send_addr = 1'b0;
    logic       txd;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       par_err;
    logic       rst_sta = 1'b0;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_md dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .baud_div(baud_div),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .send_addr(send_addr), .txd(txd), .rxd(rxd), .rx_data(rx_data),
        .rx_valid(rx_valid), .par_err(par_err), .rst_sta(rst_sta)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one byte and check each bit at its centre (R1, R2, R3, R4, R5).
    task automatic send_and_check(input logic [7:0] d, input logic addr,
                                  input logic exp_slot, input logic no_slot);
        @(negedge clk);
        if (addr) begin
            send_addr = 1'b1;
            @(negedge clk);
            send_addr = 1'b0;
        end
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(!tx_ready, "R2 busy after accept", tx_ready, 0);
        repeat (BIT_CLKS / 2 - 1) @(negedge clk);
        chk(txd == 1'b0, "R1 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT_CLKS) @(negedge clk);
            chk(txd == d[i], "R1 data bit", txd, d[i]);
        end
        repeat (BIT_CLKS) @(negedge clk);
        chk(txd == exp_slot, no_slot ? "R4 stop after data" : "R3 R5 slot bit", txd, exp_slot);
        repeat (BIT_CLKS) @(negedge clk);
        chk(txd == 1'b1, "R1 stop/idle", txd, 1);
        chk(tx_ready == no_slot, "R4 frame length", tx_ready, no_slot);
        while (!tx_ready) @(negedge clk);
    endtask

    // Drive one frame into rxd and capture the delivered byte (R6, R7, R8).
    task automatic drive_rx(input logic [7:0] d, input logic has_slot, input logic slot,
                            output logic got, output logic [7:0] gd, output logic ge);
        logic [10:0] bits;
        int n;
        bits = {1'b1, slot, d, 1'b0};
        n = has_slot ? 10 : 9;
        got = 1'b0; gd = 8'h00; ge = 1'b0;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd = bits[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = 1'b1;
        for (int i = 0; i < BIT_CLKS + 8; i++) begin
            @(negedge clk);
            if (rx_valid && !got) begin
                got = 1'b1; gd = rx_data; ge = par_err;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic got, ge;
        logic [7:0] gd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(txd == 1'b1, "R11 txd idle", txd, 1);
        chk(tx_ready == 1'b1, "R11 tx_ready", tx_ready, 1);
        chk(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
        chk(par_err == 1'b0, "R11 par_err", par_err, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] e;
            logic none;
            e = VEC[v];
            mode = e[15:13];
            none = (e[15:13] == 3'd4) || (e[15:13] == 3'd5);
            @(negedge clk);
            rst_sta = 1'b1;
            @(negedge clk);
            rst_sta = 1'b0;
            chk(par_err == 1'b0, "R9 cleared by rst_sta", par_err, 0);
            send_and_check(e[12:5], e[4], e[3], none);
            drive_rx(e[12:5], !none, e[2], got, gd, ge);
            chk(got, "R8 rx_valid pulse", got, 1);
            chk(gd == e[12:5], "R7 R8 rx data", gd, e[12:5]);
            chk(ge == e[1], none ? "R4 no error" : "R6 slot check", ge, e[1]);
        end

        // R9: error stays set across a good frame
        mode = 3'd2;
        drive_rx(8'h3C, 1'b1, 1'b1, got, gd, ge);
        chk(ge == 1'b1, "R9 error set", ge, 1);
        drive_rx(8'h3C, 1'b1, 1'b0, got, gd, ge);
        chk(par_err == 1'b1, "R9 sticky over good frame", par_err, 1);
        repeat (BIT_CLKS * 4) @(negedge clk);
        chk(par_err == 1'b1, "R9 sticky while idle", par_err, 1);

        // R10: rst_sta held through an erroring frame, set wins at stop sample
        rst_sta = 1'b1;
        @(negedge clk);
        chk(par_err == 1'b0, "R9 clear", par_err, 0);
        mode = 3'd3;
        drive_rx(8'h12, 1'b1, 1'b0, got, gd, ge);
        chk(got && ge == 1'b1, "R10 set wins over rst_sta", ge, 1);
        rst_sta = 1'b0;

        // R7: short low glitch does not start a frame
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        got = 1'b0;
        for (int i = 0; i < BIT_CLKS * 12; i++) begin
            @(negedge clk);
            if (rx_valid) got = 1'b1;
        end
        chk(!got, "R7 glitch ignored", got, 0);

        // R5: address request then a multi-drop byte, then a plain byte
        mode = 3'd6;
        send_and_check(8'hF0, 1'b1, 1'b1, 1'b0);
        send_and_check(8'hF0, 1'b0, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule